// File: doc/BRIEF.md
# Interleaved Multi-Phase PWM Generator

This block drives up to six pulse-width-modulated gate signals for synchronous buck phases that share one switching period. A master counter sets the period. Each phase runs a local count, which is the master count minus that phase's offset, modulo the period. A phase's output is high while its local count is below its effective duty. The effective duty is one shared duty command plus a signed per-phase balancing trim, clamped to the period.

The block derives the offsets itself from the live set of active phases. Software does not write them. The active phases are spread evenly around the period in ascending index order. When a phase is shed or added, the spacing is recomputed. When an enabled phase is flagged as failed, a fixed spare phase is brought in and the spacing is recomputed again. To avoid runt pulses, the period, active set, offsets and duties are captured only on the cycle where the master counter wraps.

Top module: `interleaved_pwm`

## Requirements
- R1: The master counter counts 0, 1, ... P-1 and then returns to 0. P is the period captured at the last wrap. A `period_i` value below 2 is taken as 2.
- R2: For phase i, the output `pwm_o[i]` is high exactly when ((count - off_i) mod P) is less than that phase's captured effective duty.
- R3: The effective duty is `duty_i` plus the signed two's-complement trim of phase i, taken from `trim_i[i*TW +: TW]`. Negative results become 0 and results above P become P. A duty of P keeps an active output high for the whole period.
- R4: The active set is `enable_i & ~fail_i`. If any enabled phase also has its `fail_i` bit set, and the spare phase (index SPARE, default 5) is not itself failed, the spare phase is added to the active set.
- R5: With N active phases, the k-th active phase, counted from k = 0 in ascending index order, gets offset floor(k*P/N).
- R6: An inactive phase holds its output low. When no phase is active, every output is low.
- R7: Period, active set, offsets and duties are taken from the inputs only on the cycle where count = P-1. They take effect from the following cycle, when the count is 0. Input changes at any other time do not change the outputs until that wrap.
- R8: During and just after reset all outputs are low. The internal period starts at 1, so the first clock edge after reset captures the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_i | input | CW | Switching period in counts |
| duty_i | input | CW | Shared duty command in counts |
| trim_i | input | NPH*TW | Per-phase signed duty trims, phase i at bits i*TW upward |
| enable_i | input | NPH | Requested active phases |
| fail_i | input | NPH | Phases flagged as failed |
| pwm_o | output | NPH | Gate drive outputs |

## Verification
The outputs are decoded combinationally from registered state. An input that is present at the wrap edge therefore first shows on `pwm_o` in the cycle that follows that edge. An input change at any other edge shows only after the next wrap, which can be up to P cycles later. The bench drives inputs right after a falling edge and advances its own model once per rising edge, using the inputs that edge will see. It then compares all six outputs at the next falling edge, so every cycle of every sweep is checked at the exact cycle where the result is due.

// File: rtl/ipwm_pkg.sv
package ipwm_pkg;

    localparam int unsigned PHASES_DEF = 6;
    localparam int unsigned CNT_W_DEF  = 9;
    localparam int unsigned TRIM_W_DEF = 6;
    localparam int unsigned SPARE_DEF  = 5;

    typedef enum logic [0:0] {
        CNT_RUN  = 1'b0,
        CNT_WRAP = 1'b1
    } cnt_ev_e;

endpackage

// File: rtl/ipwm_spacing.sv
module ipwm_spacing #(
    parameter int unsigned NPH   = 6,
    parameter int unsigned CW    = 9,
    parameter int unsigned SPARE = 5
) (
    input  logic [NPH-1:0]         en,
    input  logic [NPH-1:0]         fail,
    input  logic [CW-1:0]          prd,
    output logic [NPH-1:0]         act,
    output logic [NPH-1:0][CW-1:0] off
);
    localparam int unsigned RW = $clog2(NPH + 1);
    localparam int unsigned PW = CW + RW;

    logic [RW-1:0] n_act;
    logic [RW-1:0] rank;
    logic [PW-1:0] prod;
    logic [PW-1:0] quo;

    always_comb begin
        act = en & ~fail;
        if ((|(en & fail)) && !fail[SPARE]) begin
            act[SPARE] = 1'b1;
        end
        n_act = RW'($countones(act));
        rank  = '0;
        prod  = '0;
        quo   = '0;
        for (int i = 0; i < NPH; i++) begin
            prod = PW'(rank) * PW'(prd);
            quo  = (n_act != '0) ? (prod / PW'(n_act)) : '0;
            off[i] = quo[CW-1:0];
            rank = rank + RW'(act[i]);
        end
    end
endmodule

// File: rtl/ipwm_trim.sv
module ipwm_trim #(
    parameter int unsigned NPH = 6,
    parameter int unsigned CW  = 9,
    parameter int unsigned TW  = 6
) (
    input  logic [CW-1:0]          duty,
    input  logic [NPH*TW-1:0]      trim,
    input  logic [CW-1:0]          prd,
    output logic [NPH-1:0][CW-1:0] dty
);
    localparam int unsigned SW = CW + 2;

    for (genvar g = 0; g < NPH; g++) begin : g_ph
        logic [TW-1:0]        t_raw;
        logic signed [SW-1:0] sum;
        logic signed [SW-1:0] lim;

        assign t_raw = trim[g*TW +: TW];
        assign lim   = $signed({2'b00, prd});
        assign sum   = $signed({2'b00, duty}) + $signed({{(SW-TW){t_raw[TW-1]}}, t_raw});

        always_comb begin
            if (sum < 0) begin
                dty[g] = '0;
            end else if (sum > lim) begin
                dty[g] = prd;
            end else begin
                dty[g] = sum[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/ipwm_gate.sv
module ipwm_gate #(
    parameter int unsigned CW = 9
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] prd,
    input  logic [CW-1:0] off,
    input  logic [CW-1:0] dty,
    input  logic          act,
    output logic          pwm
);
    logic [CW:0] loc;

    always_comb begin
        if (cnt >= off) begin
            loc = {1'b0, cnt} - {1'b0, off};
        end else begin
            loc = {1'b0, cnt} + {1'b0, prd} - {1'b0, off};
        end
        pwm = act && (loc < {1'b0, dty});
    end
endmodule

// File: rtl/interleaved_pwm.sv
module interleaved_pwm
    import ipwm_pkg::*;
#(
    parameter int unsigned NPH   = PHASES_DEF,
    parameter int unsigned CW    = CNT_W_DEF,
    parameter int unsigned TW    = TRIM_W_DEF,
    parameter int unsigned SPARE = SPARE_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     period_i,
    input  logic [CW-1:0]     duty_i,
    input  logic [NPH*TW-1:0] trim_i,
    input  logic [NPH-1:0]    enable_i,
    input  logic [NPH-1:0]    fail_i,
    output logic [NPH-1:0]    pwm_o
);
    typedef struct packed {
        logic [CW-1:0]          cnt;
        logic [CW-1:0]          prd;
        logic [NPH-1:0]         act;
        logic [NPH-1:0][CW-1:0] off;
        logic [NPH-1:0][CW-1:0] dty;
    } state_t;

    state_t st_d, st_q;

    logic [CW-1:0]          prd_in;
    logic [NPH-1:0]         act_new;
    logic [NPH-1:0][CW-1:0] off_new;
    logic [NPH-1:0][CW-1:0] dty_new;
    cnt_ev_e                ev;

    logic [CW-1:0]          cnt_q;
    logic [CW-1:0]          prd_q;
    logic [NPH-1:0]         act_q;
    logic [NPH*CW-1:0]      dty_q;

    assign prd_in = (period_i < CW'(2)) ? CW'(2) : period_i;

    ipwm_spacing #(.NPH(NPH), .CW(CW), .SPARE(SPARE)) u_spacing (
        .en   (enable_i),
        .fail (fail_i),
        .prd  (prd_in),
        .act  (act_new),
        .off  (off_new)
    );

    ipwm_trim #(.NPH(NPH), .CW(CW), .TW(TW)) u_trim (
        .duty (duty_i),
        .trim (trim_i),
        .prd  (prd_in),
        .dty  (dty_new)
    );

    always_comb begin
        st_d = st_q;
        ev   = (st_q.cnt == st_q.prd - CW'(1)) ? CNT_WRAP : CNT_RUN;
        if (ev == CNT_WRAP) begin
            st_d.cnt = '0;
            st_d.prd = prd_in;
            st_d.act = act_new;
            st_d.off = off_new;
            st_d.dty = dty_new;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.prd <= CW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NPH; g++) begin : g_out
        ipwm_gate #(.CW(CW)) u_gate (
            .cnt (st_q.cnt),
            .prd (st_q.prd),
            .off (st_q.off[g]),
            .dty (st_q.dty[g]),
            .act (st_q.act[g]),
            .pwm (pwm_o[g])
        );
    end

    assign cnt_q = st_q.cnt;
    assign prd_q = st_q.prd;
    assign act_q = st_q.act;
    assign dty_q = st_q.dty;
endmodule

// File: rtl/interleaved_pwm_chk.sv
module interleaved_pwm_chk #(
    parameter int unsigned NPH = 6,
    parameter int unsigned CW  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW-1:0]     cnt,
    input logic [CW-1:0]     prd,
    input logic [NPH-1:0]    act,
    input logic [NPH*CW-1:0] dty,
    input logic [NPH-1:0]    pwm
);
    logic wrap;
    assign wrap = (cnt == prd - CW'(1));

    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < prd);

    a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> cnt == $past(cnt) + CW'(1));

    a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == '0);

    a_r1_period_floor: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> prd >= CW'(2));

    a_r7_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(act) && $stable(prd) && $stable(dty)));

    a_r6_inactive_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm & ~act) == '0);

    for (genvar g = 0; g < NPH; g++) begin : g_duty
        a_r3_duty_le_period: assert property (@(posedge clk) disable iff (!rst_n)
            dty[g*CW +: CW] <= prd);
    end

    always_comb begin
        if (!rst_n) begin
            a_r8_reset_low: assert (pwm == '0);
        end
    end
endmodule

bind interleaved_pwm interleaved_pwm_chk #(.NPH(NPH), .CW(CW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt_q),
    .prd   (prd_q),
    .act   (act_q),
    .dty   (dty_q),
    .pwm   (pwm_o)
);

// File: tb/test_interleaved_pwm.sv
`timescale 1ns/1ps
module test_interleaved_pwm;
    localparam int NPH = 6;
    localparam int CW  = 9;
    localparam int TW  = 6;
    localparam int SPR = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CW-1:0]     period_i = '0;
    logic [CW-1:0]     duty_i = '0;
    logic [NPH*TW-1:0] trim_i = '0;
    logic [NPH-1:0]    enable_i = '0;
    logic [NPH-1:0]    fail_i = '0;
    logic [NPH-1:0]    pwm_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    int m_cnt = 0;
    int m_p = 1;
    int m_act[NPH];
    int m_off[NPH];
    int m_dty[NPH];
    int tr[NPH];

    always #2 clk = ~clk;

    interleaved_pwm i_interleaved_pwm (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
        .trim_i(trim_i), .enable_i(enable_i), .fail_i(fail_i), .pwm_o(pwm_o)
    );

    task automatic set_trims();
        for (int i = 0; i < NPH; i++) trim_i[i*TW +: TW] = TW'(tr[i]);
    endtask

    function automatic logic [NPH-1:0] expect_out();
        logic [NPH-1:0] e = '0;
        for (int i = 0; i < NPH; i++) begin
            int loc = (m_cnt - m_off[i] + m_p) % m_p;
            e[i] = (m_act[i] != 0) && (loc < m_dty[i]);
        end
        return e;
    endfunction

    task automatic model_step();
        if (m_cnt == m_p - 1) begin
            int p = (int'(period_i) < 2) ? 2 : int'(period_i);
            int a[NPH];
            int n = 0;
            int k = 0;
            bit anyf = 0;
            for (int i = 0; i < NPH; i++) begin
                a[i] = (enable_i[i] && !fail_i[i]) ? 1 : 0;
                if (enable_i[i] && fail_i[i]) anyf = 1;
            end
            if (anyf && !fail_i[SPR]) a[SPR] = 1;
            for (int i = 0; i < NPH; i++) n += a[i];
            for (int i = 0; i < NPH; i++) begin
                int d = int'(duty_i) + tr[i];
                m_act[i] = a[i];
                m_off[i] = (n == 0) ? 0 : (k * p) / n;
                k += a[i];
                m_dty[i] = (d < 0) ? 0 : ((d > p) ? p : d);
            end
            m_p = p;
            m_cnt = 0;
        end else begin
            m_cnt++;
        end
    endtask

    task automatic check(string tag);
        logic [NPH-1:0] e = expect_out();
        n_vec++;
        if (pwm_o !== e) begin
            n_bad++;
            $display("FAIL %s cnt=%0d actual=%b expected=%b", tag, m_cnt, pwm_o, e);
        end
    endtask

    task automatic step(string tag);
        model_step();
        @(negedge clk);
        check(tag);
    endtask

    task automatic run(int cycles, string tag);
        for (int c = 0; c < cycles; c++) step(tag);
    endtask

    initial begin
        for (int i = 0; i < NPH; i++) begin
            m_act[i] = 0; m_off[i] = 0; m_dty[i] = 0; tr[i] = 0;
        end
        @(negedge clk);
        check("R8 reset");
        @(negedge clk);
        check("R8 reset");
        rst_n = 1'b1;

        // spacing over every enable mask
        period_i = 12; duty_i = 4;
        for (int m = 0; m < 64; m++) begin
            enable_i = NPH'(m);
            run(30, "R5 R2 R6 mask sweep");
        end

        // failure and spare substitution
        enable_i = 6'b011111;
        for (int f = 0; f < 64; f++) begin
            fail_i = NPH'(f);
            run(30, "R4 R5 spare swap");
        end
        fail_i = '0;

        // trims and clamping
        enable_i = '1; period_i = 10;
        for (int d = 0; d <= 10; d++) begin
            for (int t = -12; t <= 12; t += 3) begin
                duty_i = CW'(d);
                for (int i = 0; i < NPH; i++) tr[i] = t + 2 * i - 5;
                set_trims();
                run(24, "R3 trim clamp");
            end
        end
        for (int i = 0; i < NPH; i++) tr[i] = 0;
        set_trims();

        // changes away from the wrap
        enable_i = 6'b000111; period_i = 12; duty_i = 5;
        run(30, "R7 settle");
        for (int j = 0; j < 8; j++) begin
            run(3 + j, "R7 mid-period");
            enable_i = NPH'(6'b000111 ^ (j + 1));
            period_i = CW'(7 + j);
            duty_i = CW'(j);
        end
        run(40, "R7 after change");

        // reference period, and a degenerate period request
        enable_i = 6'b000111; period_i = 333; duty_i = 111;
        run(700, "R1 R5 long period");
        period_i = 0; duty_i = 1; enable_i = 6'b000011;
        run(20, "R1 period floor");
        period_i = 1;
        run(10, "R1 period floor");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule